// File: doc/BRIEF.md
# Non-Maskable Interrupt Pin Trigger Latch

This block takes an asynchronous external interrupt pad and turns it into a clean, sticky, active-high request for a parent interrupt controller. First a chain of flip-flops brings the pad into the local clock domain. Then a 2-bit trigger selector sets the polarity and chooses level or edge sensing. Any detected event sets a latch, and that latch, never the raw pad, drives the outgoing interrupt. As a result the parent always sees a level-high line, whatever the pad mode.

Software clears the request with a one-cycle clear strobe, which stands for a write of one to the pending bit. In the level modes the clear cannot take effect while the pad still holds its active level, so the request stays up until the source lets go. Enable gating and register decode sit in the enclosing controller. The trigger selector and the clear are plain control pins, and the request is a plain status level. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `nmi_trig_latch`

## Requirements
- R1: After reset, `pending_o` and `irq_o` are 0, and with the pad held high in the reset trigger mode (0) no request is raised.
- R2: Trigger code 0 raises a request while the pad is low, and code 2 raises one while the pad is high (level modes).
- R3: Trigger code 1 raises a request only on a high-to-low pad transition, and code 3 only on a low-to-high one. The opposite transition has no effect.
- R4: A pad change reaches `pending_o` on the third rising clock edge after it is applied: two synchroniser stages plus the latch.
- R5: Once set, the request stays high after the pad returns to its inactive level, until a clear is applied.
- R6: In an edge mode, a clear strobe with no new event drops `pending_o` after the next clock edge, even while the pad still sits at its active level.
- R7: In a level mode, a clear has no effect while the synchronised pad is at its active level.
- R8: If an event and a clear meet on the same clock edge, the request is set.
- R9: Changing the trigger code never produces an edge event on the edge where the change is first seen.
- R10: `irq_o` is an active-high level that always equals `pending_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pad_i | input | 1 | Asynchronous external interrupt pad |
| trig_i | input | 2 | Trigger code: 0 low level, 1 falling edge, 2 high level, 3 rising edge |
| clr_i | input | 1 | One-cycle strobe that clears the pending request |
| pending_o | output | 1 | Pending status of the latch |
| irq_o | output | 1 | Level-high request toward the parent controller |

## Verification
Some properties are checked by assertions on every cycle. These cover set-over-clear priority, that a clear alone empties the latch, that the latch holds without a clear, that a level-mode clear is refused while the source is active, and that no event appears on the edge where the trigger code changes. Other behaviour only the bench scenarios can show, because it involves pad history across several cycles. That covers the exact three-edge latency, that only the chosen edge direction sets the request, the stickiness after the pad is released, and the reset state. The bench does this by sweeping all four trigger codes through the same pad sequences, with expectations derived from the code's polarity and sense bits.

// File: rtl/nmi_trig_pkg.sv
package nmi_trig_pkg;
  // bit 1 selects active-high polarity, bit 0 selects edge sensing
  typedef enum logic [1:0] {
    TRIG_LVL_LO   = 2'd0,
    TRIG_EDGE_FAL = 2'd1,
    TRIG_LVL_HI   = 2'd2,
    TRIG_EDGE_RIS = 2'd3
  } trig_e;

  localparam int TRIG_POL_BIT  = 1;
  localparam int TRIG_EDGE_BIT = 0;

  function automatic logic trig_is_edge(trig_e t);
    return t[TRIG_EDGE_BIT];
  endfunction

  function automatic logic trig_active_high(trig_e t);
    return t[TRIG_POL_BIT];
  endfunction
endpackage

// File: rtl/nmi_pad_sync.sv
module nmi_pad_sync #(
  parameter int   STAGES = 2,
  parameter logic IDLE   = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain_q <= {STAGES{IDLE}};
    end else begin
      chain_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/nmi_sense.sv
module nmi_sense
  import nmi_trig_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_i,
  input  logic [1:0] trig_i,
  output logic       active_o,
  output logic       evt_o
);
  trig_e trig_now;
  trig_e trig_q;
  logic  hist_q;
  logic  trig_chg;

  assign trig_now = trig_e'(trig_i);
  assign active_o = trig_active_high(trig_now) ? pin_i : ~pin_i;
  assign trig_chg = (trig_now != trig_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trig_q <= TRIG_LVL_LO;
      hist_q <= 1'b0;
    end else begin
      trig_q <= trig_now;
      hist_q <= active_o;   // reload on any cycle, including a type change
    end
  end

  always_comb begin
    if (trig_is_edge(trig_now)) evt_o = active_o & ~hist_q & ~trig_chg;
    else                        evt_o = active_o;
  end

  // R9: no edge event on the first cycle a new trigger code is seen
  a_r9_no_spurious_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_i[0] && (trig_i != $past(trig_i))) |-> !evt_o);
endmodule

// File: rtl/nmi_sr_latch.sv
module nmi_sr_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)      q_o <= 1'b0;
    else if (set_i)  q_o <= 1'b1;
    else if (clr_i)  q_o <= 1'b0;
  end

  // R8: set beats clear
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && clr_i) |=> q_o);
  // R6: a lone clear empties the latch
  a_r6_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && clr_i) |=> !q_o);
  // R5: without a clear the request is held
  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (q_o && !clr_i) |=> q_o);
endmodule

// File: rtl/nmi_trig_latch.sv
module nmi_trig_latch #(
  parameter int   SYNC_STAGES = 2,
  parameter logic PAD_IDLE    = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pad_i,
  input  logic [1:0] trig_i,
  input  logic       clr_i,
  output logic       pending_o,
  output logic       irq_o
);
  logic pin_s;
  logic active;
  logic evt;
  logic latch_q;

  nmi_pad_sync #(.STAGES(SYNC_STAGES), .IDLE(PAD_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pad_i), .q_o(pin_s)
  );

  nmi_sense u_sense (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_s), .trig_i(trig_i),
    .active_o(active), .evt_o(evt)
  );

  nmi_sr_latch u_latch (
    .clk(clk), .rst_n(rst_n), .set_i(evt), .clr_i(clr_i), .q_o(latch_q)
  );

  assign pending_o = latch_q;
  assign irq_o     = latch_q;

  // R7: in a level mode a clear is refused while the source is active
  a_r7_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig_i[0] && active && clr_i) |=> pending_o);
  // R2: an active level always leaves a request behind
  a_r2_level_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig_i[0] && active) |=> pending_o);
endmodule

// File: tb/sim_nmi_trig_latch.sv
module sim_nmi_trig_latch;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pad = 1'b1;
  logic [1:0] trig = 2'd0;
  logic       clr = 1'b0;
  logic       pending, irq;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  nmi_trig_latch u0 (
    .clk(clk), .rst_n(rst_n), .pad_i(pad), .trig_i(trig), .clr_i(clr),
    .pending_o(pending), .irq_o(irq)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic exp);
    n_chk++;
    if (pending !== exp) begin
      n_bad++;
      $display("FAIL %s: pending=%b expected=%b (t=%0t)", req, pending, exp, $time);
    end
    n_chk++;
    if (irq !== pending) begin
      n_bad++;
      $display("FAIL R10: irq=%b expected=%b (t=%0t)", irq, pending, $time);
    end
  endtask

  task automatic pulse_clr();
    clr = 1'b1; tick(1); clr = 1'b0;
  endtask

  initial begin
    tick(3);
    check("R1 reset", 1'b0);
    rst_n = 1'b1;
    tick(6);
    check("R1 idle pad, mode 0", 1'b0);

    // R9: pad high, mode 0 -> 3 flips activity from 0 to 1
    pulse_clr(); tick(1);
    trig = 2'd3; tick(5);
    check("R9 no spurious edge on type change", 1'b0);

    for (int t = 0; t < 4; t++) begin
      logic pol, edg;
      pol = t[1]; edg = t[0];
      pad = ~pol; tick(4);
      trig = 2'(t); tick(4);
      pulse_clr(); tick(1);
      check("R1 clean start", 1'b0);

      // R4 latency: set on the 3rd edge after the pad change
      pad = pol; tick(2);
      check(edg ? "R4/R3 before edge" : "R4/R2 before level", 1'b0);
      tick(1);
      check(edg ? "R4/R3 edge sets" : "R4/R2 level sets", 1'b1);

      // clear while source still active
      pulse_clr();
      check(edg ? "R6 edge clear while active" : "R7 level clear refused", ~edg);

      // release the pad
      pad = ~pol; tick(4);
      check(edg ? "R3 opposite edge ignored" : "R5 sticky after release", ~edg);
      pulse_clr();
      check("R5 clear after release", 1'b0);
      tick(3);
      check("R5 stays clear", 1'b0);

      // R8: event and clear on the same edge
      pad = pol; tick(2);
      clr = 1'b1; tick(1); clr = 1'b0;
      check("R8 set wins over clear", 1'b1);
      tick(2);
      check("R5 held", 1'b1);
      pad = ~pol; tick(4);
      pulse_clr();
      check("R6 final clear", 1'b0);
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule